// File: doc/BRIEF.md
# Floating-Point Branch Resolver

This block resolves floating-point conditional branches for a pipeline that has one delay slot after each branch. When a branch instruction is presented with `inValid`, the block reads three things: the condition selector, the annul flag and the word displacement from the instruction. It tests the selector against the two-bit floating-point condition code produced by the most recent compare, and it forms the branch target relative to the branch's own PC.

One cycle later it reports four results. `outTaken` says whether the branch is taken. `outTarget` gives the target address. `outSel` tells the fetch stage how to continue. `outAnnul` tells the pipeline whether to squash the delay-slot instruction. Branch-always with the annul flag set is a special case: fetch skips the delay slot and goes straight to the target. Every other taken branch lets the slot execute first. A wrapping counter keeps a running total of taken branches.

Top module: `fbr_decide`

## Requirements
- R1: While reset is asserted and right after it, `outValid`, `outTaken`, `outAnnul`, `outSel` and `takenCount` are all zero.
- R2: The condition selector is `instr[28:25]`. The condition code encodes equal=0, less=1, greater=2, unordered=3. The selectors take the branch on these sets:
  - 1: less, greater or unordered
  - 2: less or greater
  - 3: less or unordered
  - 4: less
  - 5: greater or unordered
  - 6: greater
  - 7: unordered
  - 9: equal
  - 10: equal or unordered
  - 11: equal or greater
  - 12: anything but less
  - 13: equal or less
  - 14: anything but greater
  - 15: anything but unordered
- R3: Selector 0 is never taken and selector 8 is always taken, whatever the condition code.
- R4: `outTarget` equals `pc` plus `instr[21:0]` sign-extended from bit 21 and multiplied by 4, modulo 2^AW.
- R5: A branch that is not taken gives `outSel`=0 (sequential), and `outAnnul` equals the annul flag `instr[29]`.
- R6: Selector 8 with `instr[29]`=1 gives `outSel`=2 (direct to target, slot skipped) and `outAnnul`=1.
- R7: Any other taken branch gives `outSel`=1 (slot, then target) and `outAnnul`=0, even when `instr[29]` is 1.
- R8: The results appear on the clock edge after the one that samples `inValid`=1, with `outValid` high for that single cycle. When `outValid` is low, `outTaken` and `outAnnul` are low.
- R9: `takenCount` grows by one, wrapping at 2^CNT_W, in each cycle in which a taken result is reported. At all other times it holds its value.
- R10: Instruction bits 31:30 and 24:22 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A branch instruction is presented this cycle |
| instr | input | 32 | Branch instruction word |
| fcc | input | 2 | Current floating-point condition code |
| pc | input | AW | Address of the branch instruction |
| outValid | output | 1 | Results below are valid this cycle |
| outTaken | output | 1 | Branch is taken |
| outAnnul | output | 1 | Squash the delay-slot instruction |
| outSel | output | 2 | Next-PC choice: 0 sequential, 1 slot then target, 2 direct target |
| outTarget | output | AW | Branch target address |
| takenCount | output | CNT_W | Wrapping count of taken branches |

## Verification
An exhaustive sweep runs every selector against every condition code, once with the annul flag clear and once with it set. This separates the sixteen taken sets from one another and the three continuation cases (R5, R6, R7) from one another. Directed displacements cover the largest positive value, the most negative value, minus one and zero, on PCs placed close to the wrap point, so that a missing sign extension or a missing shift shows up. A pair of branches that differ only in the ignored bits shows those bits have no effect. Randomized branches mixed with idle cycles check the one-cycle pulse and push the taken counter through its wrap.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ         = 2'd0,
    SEL_SLOT_TARGET = 2'd1,
    SEL_DIRECT      = 2'd2
  } nextSel_e;

  typedef struct packed {
    logic     load;
    logic     taken;
    logic     annul;
    nextSel_e sel;
  } ctlStrobe_t;

  localparam int COND_W   = 4;
  localparam int NUM_COND = 1 << COND_W;
  localparam int FCC_W    = 2;
  localparam int DISP_W   = 22;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'd8;

  // Bit k of the mask set means condition code k takes the branch
  // (k: 0 equal, 1 less, 2 greater, 3 unordered).
  function automatic logic [3:0] condMask(input logic [COND_W-1:0] sel);
    case (sel)
      4'd0:  condMask = 4'b0000;
      4'd1:  condMask = 4'b1110;
      4'd2:  condMask = 4'b0110;
      4'd3:  condMask = 4'b1010;
      4'd4:  condMask = 4'b0010;
      4'd5:  condMask = 4'b1100;
      4'd6:  condMask = 4'b0100;
      4'd7:  condMask = 4'b1000;
      4'd8:  condMask = 4'b1111;
      4'd9:  condMask = 4'b0001;
      4'd10: condMask = 4'b1001;
      4'd11: condMask = 4'b0101;
      4'd12: condMask = 4'b1101;
      4'd13: condMask = 4'b0011;
      4'd14: condMask = 4'b1011;
      default: condMask = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/fbr_cond_ctl.sv
module fbr_cond_ctl
  import fbr_pkg::*;
(
  input  logic              inValid,
  input  logic [COND_W-1:0] condField,
  input  logic              annulBit,
  input  logic [FCC_W-1:0]  fcc,
  output ctlStrobe_t        strobe
);

  logic [NUM_COND-1:0] condHit;
  logic                takeIt;
  logic                directJump;

  // One evaluator per selector value; the instruction field picks one.
  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    localparam logic [3:0] MASK = condMask(COND_W'(c));
    assign condHit[c] = MASK[fcc];
  end

  assign takeIt     = condHit[condField];
  assign directJump = (condField == COND_ALWAYS) && annulBit;

  always_comb begin
    strobe.load  = inValid;
    strobe.taken = takeIt;
    if (!takeIt) begin
      strobe.annul = annulBit;
      strobe.sel   = SEL_SEQ;
    end else if (directJump) begin
      strobe.annul = 1'b1;
      strobe.sel   = SEL_DIRECT;
    end else begin
      strobe.annul = 1'b0;
      strobe.sel   = SEL_SLOT_TARGET;
    end
  end

endmodule

// File: rtl/fbr_target_dp.sv
module fbr_target_dp
  import fbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [AW-1:0]     pc,
  input  logic [DISP_W-1:0] disp,
  output logic              outValid,
  output logic              outTaken,
  output logic              outAnnul,
  output logic [1:0]        outSel,
  output logic [AW-1:0]     outTarget,
  output logic [CNT_W-1:0]  takenCount
);

  localparam int EXT_W = AW - DISP_W - 2;

  logic [AW-1:0] byteOffset;
  logic [AW-1:0] targetNext;

  assign byteOffset = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign targetNext = pc + byteOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outTaken   <= 1'b0;
      outAnnul   <= 1'b0;
      outSel     <= SEL_SEQ;
      outTarget  <= '0;
      takenCount <= '0;
    end else begin
      outValid <= strobe.load;
      outTaken <= strobe.load && strobe.taken;
      outAnnul <= strobe.load && strobe.annul;
      outSel   <= strobe.load ? strobe.sel : SEL_SEQ;
      if (strobe.load) outTarget <= targetNext;
      if (strobe.load && strobe.taken) takenCount <= takenCount + 1'b1;
    end
  end

endmodule

// File: rtl/fbr_decide.sv
module fbr_decide
  import fbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [31:0]      instr,
  input  logic [1:0]       fcc,
  input  logic [AW-1:0]    pc,
  output logic             outValid,
  output logic             outTaken,
  output logic             outAnnul,
  output logic [1:0]       outSel,
  output logic [AW-1:0]    outTarget,
  output logic [CNT_W-1:0] takenCount
);

  ctlStrobe_t strobe;
  logic       unusedInstrBits;

  assign unusedInstrBits = ^{instr[31:30], instr[24:22]};

  fbr_cond_ctl u_ctl (
    .inValid   (inValid),
    .condField (instr[28:25]),
    .annulBit  (instr[29]),
    .fcc       (fcc),
    .strobe    (strobe)
  );

  fbr_target_dp #(.AW(AW), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pc         (pc),
    .disp       (instr[DISP_W-1:0]),
    .outValid   (outValid),
    .outTaken   (outTaken),
    .outAnnul   (outAnnul),
    .outSel     (outSel),
    .outTarget  (outTarget),
    .takenCount (takenCount)
  );

endmodule

// File: rtl/fbr_decide_chk.sv
module fbr_decide_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [4:0]       brField,
  input logic             outValid,
  input logic             outTaken,
  input logic             outAnnul,
  input logic [1:0]       outSel,
  input logic [CNT_W-1:0] takenCount
);

  AST_NEVER_SELECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(brField[3:0]) == 4'd0) |-> !outTaken); // R3
  AST_ALWAYS_SELECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(brField[3:0]) == 4'd8) |-> outTaken); // R3
  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outTaken) |-> (outSel == 2'd0 && outAnnul == $past(brField[4]))); // R5
  AST_DIRECT_SKIPS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSel == 2'd2) |-> (outAnnul && outTaken)); // R6
  AST_TAKEN_RUNS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTaken && $past(brField[3:0]) != 4'd8) |-> (outSel == 2'd1 && !outAnnul)); // R7
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outTaken && !outAnnul)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTaken) |-> takenCount == $past(takenCount) + 1'b1); // R9
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outTaken) |-> $stable(takenCount)); // R9

endmodule

bind fbr_decide fbr_decide_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .brField    (instr[29:25]),
  .outValid   (outValid),
  .outTaken   (outTaken),
  .outAnnul   (outAnnul),
  .outSel     (outSel),
  .takenCount (takenCount)
);

// File: tb/test_fbr_decide.sv
module test_fbr_decide;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [31:0]   instr = '0;
  logic [1:0]    fcc = '0;
  logic [AW-1:0] pc = '0;
  logic          outValid, outTaken, outAnnul;
  logic [1:0]    outSel;
  logic [AW-1:0] outTarget;
  logic [CW-1:0] takenCount;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] expCnt = '0;

  always #5 clk = ~clk;

  fbr_decide #(.AW(AW), .CNT_W(CW)) i_fbr_decide (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .fcc(fcc), .pc(pc),
    .outValid(outValid), .outTaken(outTaken), .outAnnul(outAnnul), .outSel(outSel),
    .outTarget(outTarget), .takenCount(takenCount)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Condition code: 0 equal, 1 less, 2 greater, 3 unordered.
  function automatic bit expTaken(input logic [3:0] c, input logic [1:0] f);
    bit e, l, g, u;
    e = (f == 2'd0); l = (f == 2'd1); g = (f == 2'd2); u = (f == 2'd3);
    case (c)
      4'd0:  return 1'b0;
      4'd1:  return !e;
      4'd2:  return l || g;
      4'd3:  return l || u;
      4'd4:  return l;
      4'd5:  return u || g;
      4'd6:  return g;
      4'd7:  return u;
      4'd8:  return 1'b1;
      4'd9:  return e;
      4'd10: return e || u;
      4'd11: return e || g;
      4'd12: return !l;
      4'd13: return e || l;
      4'd14: return !g;
      default: return !u;
    endcase
  endfunction

  function automatic logic [31:0] expTarget(input logic [31:0] p, input logic [21:0] d);
    logic signed [31:0] off;
    off = $signed({d, 10'b0}) >>> 8;
    return p + off;
  endfunction

  function automatic logic [31:0] mkInstr(input logic [1:0] top, input logic a,
                                          input logic [3:0] c, input logic [2:0] mid,
                                          input logic [21:0] d);
    return {top, a, c, mid, d};
  endfunction

  task automatic runBr(input logic [31:0] ins, input logic [1:0] f, input logic [31:0] p);
    bit t;
    string rq;
    logic [1:0] eSel;
    logic eAnn;
    @(negedge clk);
    instr = ins; fcc = f; pc = p; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    t = expTaken(ins[28:25], f);
    if (!t) begin rq = "R5"; eSel = 2'd0; eAnn = ins[29]; end
    else if (ins[28:25] == 4'd8 && ins[29]) begin rq = "R6"; eSel = 2'd2; eAnn = 1'b1; end
    else begin rq = "R7"; eSel = 2'd1; eAnn = 1'b0; end
    if (t) expCnt = expCnt + 1'b1;
    chk("R8 valid", 64'(outValid), 64'd1);
    chk((ins[28:25] == 4'd0 || ins[28:25] == 4'd8) ? "R3 taken" : "R2 taken", 64'(outTaken), 64'(t));
    chk({rq, " sel"}, 64'(outSel), 64'(eSel));
    chk({rq, " annul"}, 64'(outAnnul), 64'(eAnn));
    chk("R4 target", 64'(outTarget), 64'(expTarget(p, ins[21:0])));
    chk("R9 count", 64'(takenCount), 64'(expCnt));
  endtask

  task automatic idleCycle();
    @(negedge clk);
    instr = $urandom; fcc = 2'($urandom); inValid = 1'b0;
    @(negedge clk);
    chk("R8 idle valid", 64'(outValid), 64'd0);
    chk("R8 idle taken", 64'(outTaken), 64'd0);
    chk("R8 idle annul", 64'(outAnnul), 64'd0);
    chk("R9 idle count", 64'(takenCount), 64'(expCnt));
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] vA, vB;
    logic [1:0]  sA, sB;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 64'(outValid), 64'd0);
    chk("R1 taken", 64'(outTaken), 64'd0);
    chk("R1 annul", 64'(outAnnul), 64'd0);
    chk("R1 sel", 64'(outSel), 64'd0);
    chk("R1 count", 64'(takenCount), 64'd0);
    rstN = 1'b1;
    idleCycle();

    // R2 R3 R5 R6 R7: every selector, every code, both annul settings
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 4; f++)
          runBr(mkInstr(2'b00, a[0], c[3:0], 3'b000, 22'($urandom)), f[1:0], $urandom);

    // R4: displacement corners near the address wrap
    runBr(mkInstr(2'b00, 1'b0, 4'd8, 3'b000, 22'h1FFFFF), 2'd0, 32'hFFFF_FFF0);
    runBr(mkInstr(2'b00, 1'b0, 4'd8, 3'b000, 22'h200000), 2'd0, 32'h0000_0010);
    runBr(mkInstr(2'b00, 1'b0, 4'd8, 3'b000, 22'h3FFFFF), 2'd0, 32'h0000_0000);
    runBr(mkInstr(2'b00, 1'b1, 4'd0, 3'b000, 22'h000000), 2'd3, 32'h8000_0004);

    // R10: ignored bits have no effect; compare two runs at the ports
    runBr(mkInstr(2'b00, 1'b1, 4'd9, 3'b000, 22'h012345), 2'd0, 32'h0000_4000);
    vA = outTarget; sA = outSel;
    runBr(mkInstr(2'b11, 1'b1, 4'd9, 3'b111, 22'h012345), 2'd0, 32'h0000_4000);
    vB = outTarget; sB = outSel;
    chk("R10 target", 64'(vB), 64'(vA));
    chk("R10 sel", 64'(sB), 64'(sA));

    // Random mix with idle cycles; counter wraps (R9)
    for (int i = 0; i < 400; i++) begin
      runBr($urandom, 2'($urandom), $urandom);
      if (($urandom % 4) == 0) idleCycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule